// File: doc/BRIEF.md
# Register-Cached Data Stack

This block is the operand stack of a 16-bit stack processor. Its three topmost cells live in registers: top (T), next (N) and third (N2). All of them feed the function unit directly. Cells below the third spill into a small register-file memory that a depth counter tracks. Each cycle the block applies one stack-shuffling opcode as a single-cycle permutation across T, N, N2 and the spill memory. Examples are duplicate, swap, rotate in both directions, drop, nip, tuck and the fused drop/swap forms.

The surrounding datapath can also drive a two-bit command. This command loads a result into T, or pushes a new value, or pops N into the place of a consumed operand. These are the moves that arithmetic and memory instructions need. When that command is active it takes priority and the stack opcode is ignored. A push onto a full spill memory and a pop from an empty one are reported as one-cycle flags. They are not trapped.

Top module: `data_stack`

## Requirements
- R1: The active-low asynchronous reset clears T, N, N2, the depth (depth_o = 0), ovf_o and unf_o at once, without waiting for a clock edge.
- R2: With dp_cmd_i = 0, these opcodes leave the depth unchanged: 0x0000 changes nothing; 0x0002 exchanges T and N; 0x0005 moves N2 to T, T to N and N to N2; 0x0006 moves N to T, N2 to N and T to N2.
- R3: With dp_cmd_i = 0, these opcodes push the old N2 into the spill memory and raise the depth by one: 0x0001 gives N = T and N2 = N, with T kept; 0x0004 gives T = N, N = T and N2 = N; 0x0008 gives N2 = T, with T and N kept.
- R4: With dp_cmd_i = 0, these opcodes refill N2 from the most recently spilled cell and lower the depth by one: 0x0003 gives T = N and N = N2; 0x0007 keeps T and gives N = N2; 0x0009 keeps T and N; 0x000A exchanges T and N.
- R5: Any other 16-bit opcode value, including values whose upper bits are set, leaves T, N, N2 and the depth unchanged.
- R6: dp_cmd_i selects a datapath move: 1 loads din_i into T only; 2 gives T = din_i, N = T and N2 = N and pushes the old N2; 3 gives T = din_i, N = N2 and refills N2 from the spill memory. Whenever dp_cmd_i is not 0, op_i is ignored.
- R7: The spill memory holds 32 cells. A push at depth 32 still updates the registers, but it discards the cell being spilled, leaves the depth at 32 and leaves the stored cells untouched. ovf_o is high only in the cycle that follows such a push.
- R8: A pop at depth 0 loads zero into N2 and leaves the depth at 0. unf_o is high only in the cycle that follows such a pop.
- R9: Spilled cells return to N2 in the reverse of the order in which they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 16 | Stack-shuffling opcode |
| dp_cmd_i | input | 2 | Datapath move: 0 none, 1 load T, 2 push, 3 pop |
| din_i | input | 16 | Value written into T by a datapath move |
| t_o | output | 16 | Top cell |
| n_o | output | 16 | Second cell |
| n2_o | output | 16 | Third cell |
| depth_o | output | 6 | Number of cells in the spill memory |
| ovf_o | output | 1 | Push at full depth occurred in the previous cycle |
| unf_o | output | 1 | Pop at zero depth occurred in the previous cycle |

## Verification
Two things can happen in the same cycle: a datapath pop that delivers a new T, and an underflow zero-fill of N2. The bench sets this up by moving a known value into N2 through a load followed by a reverse rotate while the spill memory is empty. It then issues a pop. The check requires T to take the new value, N to take the old N2 and N2 to read zero, with unf_o raised one cycle later.

The full-memory case overlaps in the same way. A push at depth 32 must still shift the registers while it drops the spilled cell. The drain that follows checks that the cell stored last before the overflow comes back first, which shows the discarded write did not overwrite it.

// File: rtl/dstack_pkg.sv
package dstack_pkg;

  localparam int OP_W = 16;

  localparam logic [OP_W-1:0] OP_NOP      = 16'h0000;
  localparam logic [OP_W-1:0] OP_DUP      = 16'h0001;
  localparam logic [OP_W-1:0] OP_SWAP     = 16'h0002;
  localparam logic [OP_W-1:0] OP_DROP     = 16'h0003;
  localparam logic [OP_W-1:0] OP_OVER     = 16'h0004;
  localparam logic [OP_W-1:0] OP_ROT      = 16'h0005;
  localparam logic [OP_W-1:0] OP_RROT     = 16'h0006;
  localparam logic [OP_W-1:0] OP_NIP      = 16'h0007;
  localparam logic [OP_W-1:0] OP_TUCK     = 16'h0008;
  localparam logic [OP_W-1:0] OP_DROP3    = 16'h0009;
  localparam logic [OP_W-1:0] OP_DROP3_SW = 16'h000A;

  typedef enum logic [1:0] {
    DP_NONE = 2'd0,
    DP_LOAD = 2'd1,
    DP_PUSH = 2'd2,
    DP_POP  = 2'd3
  } dp_cmd_e;

  // SRC_ALT: din for T, spill read data for N2
  typedef enum logic [1:0] {
    SRC_T   = 2'd0,
    SRC_N   = 2'd1,
    SRC_N2  = 2'd2,
    SRC_ALT = 2'd3
  } src_e;

  typedef struct packed {
    src_e t_src;
    src_e n_src;
    src_e n2_src;
    logic push;
    logic pop;
  } stack_act_t;

endpackage

// File: rtl/ds_decode.sv
module ds_decode
  import dstack_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  dp_cmd_e         dp_cmd_i,
  output stack_act_t      act_o
);

  always_comb begin
    act_o = '{t_src: SRC_T, n_src: SRC_N, n2_src: SRC_N2, push: 1'b0, pop: 1'b0};
    unique case (dp_cmd_i)
      DP_LOAD: act_o = '{SRC_ALT, SRC_N,  SRC_N2,  1'b0, 1'b0};
      DP_PUSH: act_o = '{SRC_ALT, SRC_T,  SRC_N,   1'b1, 1'b0};
      DP_POP:  act_o = '{SRC_ALT, SRC_N2, SRC_ALT, 1'b0, 1'b1};
      default: begin
        case (op_i)
          OP_DUP:      act_o = '{SRC_T,  SRC_T,  SRC_N,   1'b1, 1'b0};
          OP_SWAP:     act_o = '{SRC_N,  SRC_T,  SRC_N2,  1'b0, 1'b0};
          OP_DROP:     act_o = '{SRC_N,  SRC_N2, SRC_ALT, 1'b0, 1'b1};
          OP_OVER:     act_o = '{SRC_N,  SRC_T,  SRC_N,   1'b1, 1'b0};
          OP_ROT:      act_o = '{SRC_N2, SRC_T,  SRC_N,   1'b0, 1'b0};
          OP_RROT:     act_o = '{SRC_N,  SRC_N2, SRC_T,   1'b0, 1'b0};
          OP_NIP:      act_o = '{SRC_T,  SRC_N2, SRC_ALT, 1'b0, 1'b1};
          OP_TUCK:     act_o = '{SRC_T,  SRC_N,  SRC_T,   1'b1, 1'b0};
          OP_DROP3:    act_o = '{SRC_T,  SRC_N,  SRC_ALT, 1'b0, 1'b1};
          OP_DROP3_SW: act_o = '{SRC_N,  SRC_T,  SRC_ALT, 1'b0, 1'b1};
          default:     act_o = '{SRC_T,  SRC_N,  SRC_N2,  1'b0, 1'b0};
        endcase
      end
    endcase
  end

endmodule

// File: rtl/ds_spill.sv
module ds_spill #(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic [DW-1:0]            wdata_i,
  output logic [DW-1:0]            rdata_o,
  output logic [$clog2(DEPTH):0]   count_o,
  output logic                     ovf_o,
  output logic                     unf_o
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DW-1:0] mem_q [DEPTH];
  logic [CW-1:0] count_q;
  logic [CW-1:0] top_idx;
  logic          full, empty;
  logic          ovf_q, unf_q;

  assign full    = (count_q == FULL_CNT);
  assign empty   = (count_q == '0);
  assign top_idx = count_q - 1'b1;
  assign rdata_o = empty ? '0 : mem_q[top_idx[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (push_i && !full) mem_q[count_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      unf_q   <= 1'b0;
    end else begin
      ovf_q <= push_i && full;
      unf_q <= pop_i && empty;
      if (push_i && !full)      count_q <= count_q + 1'b1;
      else if (pop_i && !empty) count_q <= count_q - 1'b1;
    end
  end

  assign count_o = count_q;
  assign ovf_o   = ovf_q;
  assign unf_o   = unf_q;

endmodule

// File: rtl/data_stack.sv
module data_stack
  import dstack_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [OP_W-1:0]        op_i,
  input  logic [1:0]             dp_cmd_i,
  input  logic [DW-1:0]          din_i,
  output logic [DW-1:0]          t_o,
  output logic [DW-1:0]          n_o,
  output logic [DW-1:0]          n2_o,
  output logic [$clog2(DEPTH):0] depth_o,
  output logic                   ovf_o,
  output logic                   unf_o
);

  stack_act_t    act;
  logic [DW-1:0] t_q, n_q, n2_q;
  logic [DW-1:0] t_d, n_d, n2_d;
  logic [DW-1:0] spill_rd;

  ds_decode i_decode (
    .op_i     (op_i),
    .dp_cmd_i (dp_cmd_e'(dp_cmd_i)),
    .act_o    (act)
  );

  ds_spill #(.DW(DW), .DEPTH(DEPTH)) i_spill (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (act.push),
    .pop_i   (act.pop),
    .wdata_i (n2_q),
    .rdata_o (spill_rd),
    .count_o (depth_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );

  function automatic logic [DW-1:0] pick(src_e s, logic [DW-1:0] t, logic [DW-1:0] n,
                                         logic [DW-1:0] n2, logic [DW-1:0] alt);
    case (s)
      SRC_T:   return t;
      SRC_N:   return n;
      SRC_N2:  return n2;
      default: return alt;
    endcase
  endfunction

  always_comb begin
    t_d  = pick(act.t_src,  t_q, n_q, n2_q, din_i);
    n_d  = pick(act.n_src,  t_q, n_q, n2_q, n_q);
    n2_d = pick(act.n2_src, t_q, n_q, n2_q, spill_rd);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q  <= '0;
      n_q  <= '0;
      n2_q <= '0;
    end else begin
      t_q  <= t_d;
      n_q  <= n_d;
      n2_q <= n2_d;
    end
  end

  assign t_o  = t_q;
  assign n_o  = n_q;
  assign n2_o = n2_q;

endmodule

// File: rtl/ds_checker.sv
module ds_checker
  import dstack_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [OP_W-1:0]        op_i,
  input logic [1:0]             dp_cmd_i,
  input logic [DW-1:0]          t_o,
  input logic [DW-1:0]          n_o,
  input logic [DW-1:0]          n2_o,
  input logic [$clog2(DEPTH):0] depth_o,
  input logic                   ovf_o,
  input logic                   unf_o
);

  AST_SWAP_EXCHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_cmd_i == 2'd0 && op_i == OP_SWAP) |=>
      (t_o == $past(n_o) && n_o == $past(t_o) && n2_o == $past(n2_o) && depth_o == $past(depth_o))); // R2

  AST_UNKNOWN_OP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_cmd_i == 2'd0 && op_i > OP_DROP3_SW) |=>
      (t_o == $past(t_o) && n_o == $past(n_o) && n2_o == $past(n2_o) && depth_o == $past(depth_o))); // R5

  AST_LOAD_T_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_cmd_i == 2'd1) |=>
      (n_o == $past(n_o) && n2_o == $past(n2_o) && depth_o == $past(depth_o))); // R6

  AST_PUSH_GROWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dp_cmd_i == 2'd2 && depth_o < DEPTH) |=> (depth_o == $past(depth_o) + 1'b1)); // R6

  AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DEPTH); // R7

  AST_OVF_AT_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (depth_o == DEPTH)); // R7

  AST_UNF_ZERO_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (n2_o == '0 && depth_o == '0)); // R8

endmodule

bind data_stack ds_checker #(.DW(DW), .DEPTH(DEPTH)) i_ds_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .dp_cmd_i (dp_cmd_i),
  .t_o      (t_o),
  .n_o      (n_o),
  .n2_o     (n2_o),
  .depth_o  (depth_o),
  .ovf_o    (ovf_o),
  .unf_o    (unf_o)
);

// File: tb/test_data_stack.sv
module test_data_stack;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] op_i = '0;
  logic [1:0]  dp_cmd_i = '0;
  logic [15:0] din_i = '0;
  logic [15:0] t_o, n_o, n2_o;
  logic [5:0]  depth_o;
  logic        ovf_o, unf_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk_i = ~clk_i;

  data_stack i_data_stack (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .dp_cmd_i(dp_cmd_i), .din_i(din_i),
    .t_o(t_o), .n_o(n_o), .n2_o(n2_o), .depth_o(depth_o), .ovf_o(ovf_o), .unf_o(unf_o)
  );

  // {op, dp_cmd, din, T, N, N2, depth}
  localparam int NV = 20;
  localparam logic [87:0] VEC [NV] = '{
    {16'h0000, 2'd2, 16'h1111, 16'h1111, 16'h0000, 16'h0000, 6'd1},
    {16'h0000, 2'd2, 16'h2222, 16'h2222, 16'h1111, 16'h0000, 6'd2},
    {16'h0000, 2'd2, 16'h3333, 16'h3333, 16'h2222, 16'h1111, 6'd3},
    {16'h0000, 2'd2, 16'h4444, 16'h4444, 16'h3333, 16'h2222, 6'd4},
    {16'h0002, 2'd0, 16'h0000, 16'h3333, 16'h4444, 16'h2222, 6'd4},
    {16'h0005, 2'd0, 16'h0000, 16'h2222, 16'h3333, 16'h4444, 6'd4},
    {16'h0006, 2'd0, 16'h0000, 16'h3333, 16'h4444, 16'h2222, 6'd4},
    {16'h0004, 2'd0, 16'h0000, 16'h4444, 16'h3333, 16'h4444, 6'd5},
    {16'h0007, 2'd0, 16'h0000, 16'h4444, 16'h4444, 16'h2222, 6'd4},
    {16'h0008, 2'd0, 16'h0000, 16'h4444, 16'h4444, 16'h4444, 6'd5},
    {16'h0009, 2'd0, 16'h0000, 16'h4444, 16'h4444, 16'h2222, 6'd4},
    {16'h0002, 2'd1, 16'hABCD, 16'hABCD, 16'h4444, 16'h2222, 6'd4},
    {16'h000A, 2'd0, 16'h0000, 16'h4444, 16'hABCD, 16'h1111, 6'd3},
    {16'h0003, 2'd0, 16'h0000, 16'hABCD, 16'h1111, 16'h0000, 6'd2},
    {16'h0001, 2'd3, 16'h5555, 16'h5555, 16'h0000, 16'h0000, 6'd1},
    {16'h0001, 2'd0, 16'h0000, 16'h5555, 16'h5555, 16'h0000, 6'd2},
    {16'h000B, 2'd0, 16'h0000, 16'h5555, 16'h5555, 16'h0000, 6'd2},
    {16'h0105, 2'd0, 16'h0000, 16'h5555, 16'h5555, 16'h0000, 6'd2},
    {16'hFFFF, 2'd0, 16'h0000, 16'h5555, 16'h5555, 16'h0000, 6'd2},
    {16'h0000, 2'd0, 16'h0000, 16'h5555, 16'h5555, 16'h0000, 6'd2}
  };

  function automatic string vtag(int i);
    case (i)
      0, 1, 2, 3, 11, 14: return "R6";
      4, 5, 6, 19:        return "R2";
      7, 9, 15:           return "R3";
      8, 10, 12, 13:      return "R4";
      default:            return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  // call at a negedge; returns at the next negedge with outputs settled
  task automatic step(logic [15:0] op, logic [1:0] dp, logic [15:0] din);
    op_i = op; dp_cmd_i = dp; din_i = din;
    @(negedge clk_i);
  endtask

  function automatic logic [63:0] state();
    return {8'h0, t_o, n_o, n2_o, depth_o, ovf_o, unf_o};
  endfunction

  function automatic logic [63:0] mk(logic [15:0] t, logic [15:0] n, logic [15:0] n2,
                                     logic [5:0] d, logic ov, logic un);
    return {8'h0, t, n, n2, d, ov, un};
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 reset state", state(), mk(0, 0, 0, 0, 0, 0));
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][87:72], VEC[i][71:70], VEC[i][69:54]);
      check(vtag(i), state(), {8'h0, VEC[i][53:0], 2'b00});
    end

    // R1: reset acts without a clock edge
    #1 rst_ni = 1'b0;
    #1 check("R1 async clear", state(), mk(0, 0, 0, 0, 0, 0));
    @(negedge clk_i); rst_ni = 1'b1;

    // R8: pop on empty memory combined with a datapath load of T
    step(16'h0000, 2'd1, 16'h0007);
    step(16'h0006, 2'd0, 16'h0000);
    check("R8 setup", state(), mk(0, 0, 16'h0007, 0, 0, 0));
    step(16'h0000, 2'd3, 16'h00AA);
    check("R8 pop at empty", state(), mk(16'h00AA, 16'h0007, 0, 0, 0, 1));
    step(16'h0000, 2'd0, 16'h0000);
    check("R8 flag pulse ends", state(), mk(16'h00AA, 16'h0007, 0, 0, 0, 0));
    step(16'h0003, 2'd0, 16'h0000);
    check("R8 drop at empty", state(), mk(16'h0007, 0, 0, 0, 0, 1));

    // R7: fill to 32 and push once more
    rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    for (int k = 1; k <= 32; k++) step(16'h0000, 2'd2, 16'(k));
    check("R7 full", state(), mk(16'd32, 16'd31, 16'd30, 6'd32, 0, 0));
    step(16'h0000, 2'd2, 16'd33);
    check("R7 push at full", state(), mk(16'd33, 16'd32, 16'd31, 6'd32, 1, 0));
    step(16'h0000, 2'd0, 16'h0000);
    check("R7 flag pulse ends", state(), mk(16'd33, 16'd32, 16'd31, 6'd32, 0, 0));

    // R9: drain; N2 must return cells newest first (cell j held j-2)
    for (int d = 31; d >= 0; d--) begin
      step(16'h0003, 2'd0, 16'h0000);
      check("R9 drain", {32'h0, n2_o, 10'h0, depth_o},
            {32'h0, (d >= 2) ? 16'(d - 2) : 16'h0, 10'h0, 6'(d)});
    end

    summary();
  end

endmodule